// File: doc/BRIEF.md
# Aperture Page-Remapping Address Translator

This block sits on an inbound bus path and rewrites addresses that land inside a configurable remapping window. Software programs two configuration words, a control word (enable and a size order) and a base word (a 15-bit field in 32 MiB units). From these the block derives the window's base and length. A bus address that falls in the window is split into a 4 KiB page index and a page offset. The index selects a 32-bit page entry in a small internal table, and the entry supplies a 40-bit physical page address.

A request is accepted on `req_valid` while `req_ready` is high. The response is a one-cycle pulse on `rsp_valid` carrying the address, a hit flag, a fault flag and the page's coherent flag. A single-entry translation cache keeps the most recently fetched index and its entry. A request served from the cache, or one that needs no table read, answers one cycle after acceptance. A request that must read the table answers after two cycles. Software fills the table through a write port. A `flush` pulse discards the cached translation, as does a configuration write or a table write to the cached index.

Top module: `aper_xlate`

## Requirements
- R1: After reset, `rsp_valid` is 0, `req_ready` is 1, translation is off (every request passes through with hit=0), and every table entry reads as invalid (an in-window request faults once the window is enabled).
- R2: A configuration write with `cfg_sel`=0 loads the control word: bit 0 is the enable and bits 3:1 are the order N. The window length is 32 MiB << N. A write with `cfg_sel`=1 loads the base field from bits 14:0, and the window base is that field << 25. An address A is in the window when base <= A < base+length.
- R3: The window is inactive, and every request passes through, when the enable is 0, when the base field is 0, or when base+length exceeds 4 GiB. A window that ends exactly at 4 GiB is active.
- R4: A request outside the active window responds with `rsp_addr` equal to the bus address zero-extended to 40 bits, hit=0, fault=0, coherent=0, one cycle after acceptance.
- R5: An in-window request uses table index (A-base)>>12. When the entry E has bit 0 set and bits 3:2 clear, the response is hit=1, fault=0, coherent=E[1], and `rsp_addr` = {E[11:4], E[31:12], A[11:0]}.
- R6: An in-window request faults (hit=1, fault=1, `rsp_addr`=0, coherent=0) when its index is at or beyond the table depth, or when its entry has bit 0 clear or a nonzero bit in 3:2. The out-of-depth case answers in one cycle.
- R7: A request that must read the table has `rsp_valid` two cycles after acceptance, with `req_ready` low in the cycle between. Out-of-window, out-of-depth and cache-hit requests answer after one cycle.
- R8: After a table read for index I, a later request for I is served from the cache in one cycle with the same result.
- R9: A `flush` pulse empties the cache. A request accepted in the same cycle as `flush` does not use the cache.
- R10: A table write to the cached index empties the cache, including when it falls in the same cycle as a request for that index. That request then reads the newly written entry. A write to any other index leaves the cache intact.
- R11: Any configuration write empties the cache.
- R12: A table write to the index being read, in the cycle the read takes place, does not alter that response: the old entry is used. The cache is not filled, so the next request for that index reads the table again and sees the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the control word, 1 the base word |
| cfg_wdata | input | 15 | Configuration write data |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | $clog2(TBL_DEPTH) | Table write index |
| tbl_wdata | input | 32 | Page entry to write |
| flush | input | 1 | Discard the cached translation |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | 32 | Bus address to translate |
| rsp_valid | output | 1 | Response pulse |
| rsp_addr | output | 40 | Resulting physical address |
| rsp_hit | output | 1 | Address fell in the active window |
| rsp_fault | output | 1 | In-window access without a usable entry |
| rsp_coherent | output | 1 | Coherent flag of the used entry |

## Verification
Two functions can act in the same cycle: a cache lookup, and an event that empties the cache. The emptying event is a flush, a table write to the cached index, or a write during the table read itself. The bench provokes these by asserting `flush` or `tbl_we` in the very cycle a request is accepted, and by writing the fetched index during the read cycle. It judges each case by the response latency (one cycle against two) and by whether the old or the new entry appears. A reference model in the bench tracks the table, the cache tag and the window, and predicts both values.

// File: rtl/aptr_pkg.sv
package aptr_pkg;
    localparam int BUS_W    = 32;
    localparam int PHYS_W   = 40;
    localparam int PG_SH    = 12;
    localparam int PIDX_W   = BUS_W - PG_SH;
    localparam int WIN_SH   = 25;
    localparam int ORD_W    = 3;
    localparam int BASEF_W  = 15;
    localparam int ENT_W    = 32;
    localparam int SIZE_W   = BUS_W + 1;

    typedef enum logic {ST_IDLE, ST_FETCH} st_e;

    typedef struct packed {
        logic              hit;
        logic              fault;
        logic              coh;
        logic [PHYS_W-1:0] addr;
    } rsp_t;

    // Turn a page entry plus page offset into a response.
    function automatic rsp_t make_rsp(input logic [ENT_W-1:0] e,
                                      input logic [PG_SH-1:0] off);
        rsp_t r;
        r.hit = 1'b1;
        if (e[0] && (e[3:2] == 2'b00)) begin
            r.fault = 1'b0;
            r.coh   = e[1];
            r.addr  = {e[11:4], e[31:12], off};
        end else begin
            r.fault = 1'b1;
            r.coh   = 1'b0;
            r.addr  = '0;
        end
        return r;
    endfunction
endpackage

// File: rtl/aptr_cfg.sv
module aptr_cfg
    import aptr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic               cfg_sel,
    input  logic [BASEF_W-1:0] cfg_wdata,
    output logic               ap_active,
    output logic [BUS_W-1:0]   ap_base,
    output logic [SIZE_W-1:0]  ap_size
);
    typedef struct packed {
        logic               en;
        logic [ORD_W-1:0]   ord;
        logic [BASEF_W-1:0] basef;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [PHYS_W-1:0] base_full;
    logic [PHYS_W:0]   win_end;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            if (cfg_sel) begin
                cfg_d.basef = cfg_wdata;
            end else begin
                cfg_d.en  = cfg_wdata[0];
                cfg_d.ord = cfg_wdata[ORD_W:1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        base_full = PHYS_W'(cfg_q.basef) << WIN_SH;
        ap_size   = SIZE_W'(1) << (WIN_SH + int'(cfg_q.ord));
        win_end   = {1'b0, base_full} + (PHYS_W + 1)'(ap_size);
        ap_active = cfg_q.en && (cfg_q.basef != '0) &&
                    (win_end <= ((PHYS_W + 1)'(1) << BUS_W));
        ap_base   = base_full[BUS_W-1:0];
    end

    // R3
    active_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ap_active |-> (ap_base != '0));
endmodule

// File: rtl/aptr_table.sv
module aptr_table
    import aptr_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [ENT_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [ENT_W-1:0] rd_data
);
    logic [ENT_W-1:0] mem_d [DEPTH];
    logic [ENT_W-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) mem_d[wr_idx] = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '{default: '0};
        else        mem_q <= mem_d;
    end

    assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/aptr_cache.sv
module aptr_cache
    import aptr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIDX_W-1:0] lk_idx,
    output logic              lk_hit,
    output logic [ENT_W-1:0]  lk_entry,
    input  logic              inval_all,
    input  logic              wr_en,
    input  logic [PIDX_W-1:0] wr_idx,
    input  logic              fill_en,
    input  logic [PIDX_W-1:0] fill_idx,
    input  logic [ENT_W-1:0]  fill_entry
);
    typedef struct packed {
        logic              vld;
        logic [PIDX_W-1:0] tag;
        logic [ENT_W-1:0]  ent;
    } line_t;

    line_t line_d, line_q;
    logic  kill;

    always_comb begin
        kill     = inval_all || (wr_en && line_q.vld && (wr_idx == line_q.tag));
        lk_hit   = line_q.vld && (line_q.tag == lk_idx) && !kill;
        lk_entry = line_q.ent;
        line_d   = line_q;
        if (kill) line_d.vld = 1'b0;
        if (fill_en) begin
            line_d.vld = 1'b1;
            line_d.tag = fill_idx;
            line_d.ent = fill_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_d;
    end

    // R9
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inval_all && !fill_en) |=> !line_q.vld);

    // R10
    tag_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && line_q.vld && (wr_idx == line_q.tag) && !fill_en) |=> !line_q.vld);
endmodule

// File: rtl/aper_xlate.sv
module aper_xlate
    import aptr_pkg::*;
#(
    parameter int TBL_DEPTH = 256,
    localparam int IDX_W = $clog2(TBL_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic               cfg_sel,
    input  logic [BASEF_W-1:0] cfg_wdata,
    input  logic               tbl_we,
    input  logic [IDX_W-1:0]   tbl_idx,
    input  logic [ENT_W-1:0]   tbl_wdata,
    input  logic               flush,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [BUS_W-1:0]   req_addr,
    output logic               rsp_valid,
    output logic [PHYS_W-1:0]  rsp_addr,
    output logic               rsp_hit,
    output logic               rsp_fault,
    output logic               rsp_coherent
);
    typedef struct packed {
        st_e              st;
        logic [IDX_W-1:0] fidx;
        logic [PG_SH-1:0] foff;
        logic             rvld;
        rsp_t             rsp;
    } core_t;

    core_t s_d, s_q;

    logic              ap_active;
    logic [BUS_W-1:0]  ap_base;
    logic [SIZE_W-1:0] ap_size;
    logic [BUS_W-1:0]  off;
    logic [PIDX_W-1:0] pidx;
    logic              in_win, in_tbl, accept;
    logic              lk_hit, fill_en;
    logic [ENT_W-1:0]  lk_entry, rd_data;
    logic [PIDX_W-1:0] wr_idx_ext, fill_idx_ext;

    aptr_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .ap_active(ap_active), .ap_base(ap_base),
        .ap_size(ap_size)
    );

    aptr_table #(.DEPTH(TBL_DEPTH)) u_tbl (
        .clk(clk), .rst_n(rst_n), .wr_en(tbl_we), .wr_idx(tbl_idx),
        .wr_data(tbl_wdata), .rd_idx(s_q.fidx), .rd_data(rd_data)
    );

    assign wr_idx_ext   = PIDX_W'(tbl_idx);
    assign fill_idx_ext = PIDX_W'(s_q.fidx);

    aptr_cache u_cache (
        .clk(clk), .rst_n(rst_n), .lk_idx(pidx), .lk_hit(lk_hit),
        .lk_entry(lk_entry), .inval_all(flush || cfg_we), .wr_en(tbl_we),
        .wr_idx(wr_idx_ext), .fill_en(fill_en), .fill_idx(fill_idx_ext),
        .fill_entry(rd_data)
    );

    always_comb begin
        off    = req_addr - ap_base;
        pidx   = off[BUS_W-1:PG_SH];
        in_win = ap_active && (req_addr >= ap_base) && ({1'b0, off} < ap_size);
        in_tbl = ({1'b0, pidx} < (PIDX_W + 1)'(TBL_DEPTH));
        accept = req_valid && (s_q.st == ST_IDLE);
        fill_en = 1'b0;

        s_d      = s_q;
        s_d.rvld = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (accept) begin
                    if (!in_win) begin
                        s_d.rvld = 1'b1;
                        s_d.rsp  = '{hit: 1'b0, fault: 1'b0, coh: 1'b0,
                                     addr: PHYS_W'(req_addr)};
                    end else if (!in_tbl) begin
                        s_d.rvld = 1'b1;
                        s_d.rsp  = '{hit: 1'b1, fault: 1'b1, coh: 1'b0, addr: '0};
                    end else if (lk_hit) begin
                        s_d.rvld = 1'b1;
                        s_d.rsp  = make_rsp(lk_entry, off[PG_SH-1:0]);
                    end else begin
                        s_d.st   = ST_FETCH;
                        s_d.fidx = pidx[IDX_W-1:0];
                        s_d.foff = off[PG_SH-1:0];
                    end
                end
            end
            default: begin
                s_d.st   = ST_IDLE;
                s_d.rvld = 1'b1;
                s_d.rsp  = make_rsp(rd_data, s_q.foff);
                fill_en  = !(flush || cfg_we || (tbl_we && (tbl_idx == s_q.fidx)));
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign req_ready    = (s_q.st == ST_IDLE);
    assign rsp_valid    = s_q.rvld;
    assign rsp_addr     = s_q.rsp.addr;
    assign rsp_hit      = s_q.rsp.hit;
    assign rsp_fault    = s_q.rsp.fault;
    assign rsp_coherent = s_q.rsp.coh;

    // R6
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_hit && (rsp_addr == '0) && !rsp_coherent));

    // R4
    pass_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (!rsp_fault && (rsp_addr[PHYS_W-1:BUS_W] == '0)));

    // R7
    fetch_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_FETCH) |=> (rsp_valid && req_ready));

    // R3
    off_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !ap_active) |=> (rsp_valid && !rsp_hit));
endmodule

// File: tb/aper_xlate_tb.sv
module aper_xlate_tb;
    localparam int DEPTH = 256;
    localparam int IW    = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          cfg_we = 0, cfg_sel = 0;
    logic [14:0]   cfg_wdata = '0;
    logic          tbl_we = 0;
    logic [IW-1:0] tbl_idx = '0;
    logic [31:0]   tbl_wdata = '0;
    logic          flush = 0, req_valid = 0;
    logic [31:0]   req_addr = '0;
    logic          req_ready, rsp_valid, rsp_hit, rsp_fault, rsp_coherent;
    logic [39:0]   rsp_addr;

    aper_xlate #(.TBL_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
        .tbl_wdata(tbl_wdata), .flush(flush), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
        .rsp_addr(rsp_addr), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
        .rsp_coherent(rsp_coherent)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // reference model
    logic [31:0] mt [DEPTH];
    bit          m_en = 0;
    int          m_ord = 0, m_bf = 0;
    bit          cvld = 0;
    int          ctag = 0;

    task automatic check(input string tag, input bit ok, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] m_base();
        return 64'(m_bf) << 25;
    endfunction
    function automatic logic [63:0] m_size();
        return 64'd1 << (25 + m_ord);
    endfunction
    function automatic bit m_active();
        return m_en && (m_bf != 0) && (m_base() + m_size() <= 64'h1_0000_0000);
    endfunction
    function automatic logic [42:0] dec(input logic [31:0] e, input logic [11:0] o);
        // {hit, fault, coh, addr}
        if (e[0] && e[3:2] == 2'b00) return {1'b1, 1'b0, e[1], e[11:4], e[31:12], o};
        return {1'b1, 1'b1, 1'b0, 40'h0};
    endfunction

    task automatic do_cfg(input bit sel, input int data);
        cfg_we = 1; cfg_sel = sel; cfg_wdata = 15'(data);
        @(negedge clk);
        cfg_we = 0;
        if (sel) m_bf = data & 16'h7fff;
        else begin m_en = data[0]; m_ord = (data >> 1) & 7; end
        cvld = 0;
    endtask

    task automatic do_tw(input int idx, input logic [31:0] d);
        tbl_we = 1; tbl_idx = IW'(idx); tbl_wdata = d;
        @(negedge clk);
        tbl_we = 0;
        mt[idx] = d;
        if (cvld && ctag == idx) cvld = 0;
    endtask

    task automatic check_rsp(input string tag, input logic [42:0] exp);
        logic [42:0] act;
        act = {rsp_hit, rsp_fault, rsp_coherent, rsp_addr};
        check(tag, rsp_valid == 1'b1, "rsp_valid", 64'(rsp_valid), 64'd1);
        check(tag, act == exp, "{hit,fault,coh,addr}", 64'(act), 64'(exp));
    endtask

    task automatic do_req(input logic [31:0] a, input bit fl, input bit wr,
                          input int widx, input logic [31:0] wd,
                          input bit fwr, input logic [31:0] fwd, input string tag);
        logic [63:0] base, size;
        bit inap, intbl, kill, lat2;
        int idx;
        logic [42:0] exp;
        logic [31:0] e;
        base  = m_base();
        size  = m_size();
        inap  = m_active() && (64'(a) >= base) && (64'(a) < base + size);
        idx   = inap ? int'((64'(a) - base) >> 12) : 0;
        intbl = idx < DEPTH;
        kill  = fl || (wr && cvld && widx == ctag);
        lat2  = inap && intbl && !(cvld && ctag == idx && !kill);
        req_valid = 1; req_addr = a; flush = fl;
        tbl_we = wr; tbl_idx = IW'(widx); tbl_wdata = wd;
        @(negedge clk);
        req_valid = 0; flush = 0; tbl_we = 0;
        if (kill) cvld = 0;
        if (wr) mt[widx] = wd;
        if (!lat2) begin
            if (!inap)       exp = {3'b000, 8'h0, a};
            else if (!intbl) exp = {3'b110, 40'h0};
            else             exp = dec(mt[idx], a[11:0]);
            check_rsp(tag, exp);
        end else begin
            check(tag, !rsp_valid && !req_ready, "fetch gap latency (R7)",
                  64'({rsp_valid, req_ready}), 64'd0);
            e = mt[idx];
            if (fwr) begin
                tbl_we = 1; tbl_idx = IW'(idx); tbl_wdata = fwd;
            end
            @(negedge clk);
            tbl_we = 0;
            if (fwr) mt[idx] = fwd;
            else begin cvld = 1; ctag = idx; end
            check_rsp(tag, dec(e, a[11:0]));
        end
    endtask

    task automatic rq(input logic [31:0] a, input string tag);
        do_req(a, 0, 0, 0, 32'h0, 0, 32'h0, tag);
    endtask

    function automatic logic [31:0] ent(input logic [19:0] lo, input logic [7:0] hi,
                                        input bit coh);
        return {lo, hi, 2'b00, coh, 1'b1};
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] b;
        void'($urandom(32'd7));
        for (int i = 0; i < DEPTH; i++) mt[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1", rsp_valid == 0 && req_ready == 1, "{rsp_valid,req_ready}",
              64'({rsp_valid, req_ready}), 64'd1);
        rq(32'h0400_1234, "R1");
        do_cfg(1, 2);
        do_cfg(0, 3);                       // enable, order 1 -> 64 MiB at 0x0400_0000
        b = 32'h0400_0000;
        rq(b + 5 * 4096 + 12'h010, "R1");   // empty table faults
        // R5 / R8
        do_tw(5, ent(20'hABCDE, 8'h3C, 1));
        rq(b + 5 * 4096 + 12'h777, "R5");
        rq(b + 5 * 4096 + 12'h001, "R8");
        do_tw(7, ent(20'h12345, 8'hF0, 0));
        rq(b + 7 * 4096 + 12'hFFF, "R5");
        // R4 window edges
        rq(32'h03FF_FFFF, "R4");
        rq(32'h0800_0000, "R4");
        rq(32'h07FF_FFFF, "R6");            // in window, beyond table depth
        rq(b + (DEPTH - 1) * 4096, "R6");   // last entry, still empty
        do_tw(6, ent(20'h11111, 8'h01, 0) | 32'h4);
        rq(b + 6 * 4096, "R6");             // reserved bit set
        // R9 flush collides with request
        rq(b + 5 * 4096, "R8");
        do_req(b + 5 * 4096 + 12'h020, 1, 0, 0, 0, 0, 0, "R9");
        rq(b + 5 * 4096 + 12'h030, "R9");
        // R10 write collides with request to cached index
        do_req(b + 5 * 4096 + 12'h040, 0, 1, 5, ent(20'h55555, 8'h77, 0), 0, 0, "R10");
        do_req(b + 5 * 4096 + 12'h050, 0, 1, 9, ent(20'h99999, 8'h09, 1), 0, 0, "R10");
        rq(b + 9 * 4096, "R10");
        // R11 configuration write empties cache
        rq(b + 9 * 4096 + 12'h004, "R11");
        do_cfg(0, 3);
        rq(b + 9 * 4096 + 12'h008, "R11");
        // R12 write during the table read
        do_tw(2, ent(20'h22222, 8'h02, 0));
        do_req(b + 2 * 4096 + 12'h100, 0, 0, 0, 0, 1, ent(20'h33333, 8'h03, 1), "R12");
        rq(b + 2 * 4096 + 12'h200, "R12");
        rq(b + 2 * 4096 + 12'h300, "R12");
        // R2 / R3 configuration decoding
        do_cfg(1, 4); do_cfg(0, 5);         // base 0x0800_0000, 128 MiB
        rq(32'h0800_0000 + 5 * 4096 + 12'h0AB, "R2");
        rq(32'h0FFF_FFFF, "R2");
        rq(32'h1000_0000, "R2");
        do_cfg(1, 15'h79); do_cfg(0, 7);    // ends past 4 GiB
        rq(32'hF200_1000, "R3");
        do_cfg(1, 15'h78);                  // ends exactly at 4 GiB
        rq(32'hF000_0000 + 5 * 4096 + 12'h123, "R3");
        rq(32'hFFFF_FFFF, "R3");
        do_cfg(0, 6);                       // enable cleared
        rq(32'hF000_5000, "R3");
        do_cfg(0, 7); do_cfg(1, 0);         // base field zero
        rq(32'h0000_5000, "R3");
        do_cfg(1, 1); do_cfg(0, 15);        // order 7: 4 GiB never fits
        rq(32'h0200_5000, "R3");
        // random phase
        do_cfg(1, 2); do_cfg(0, 3);
        for (int it = 0; it < 400; it++) begin
            int sel, idx;
            logic [31:0] a, d;
            sel = int'($urandom % 20);
            d = $urandom;
            if ($urandom % 4 != 0) d[3:0] = {2'b00, d[1], 1'b1};
            idx = ($urandom % 3 == 0) ? int'($urandom % DEPTH) : int'($urandom % 8);
            if (sel < 3) begin
                do_tw(idx, d);
            end else begin
                int r;
                r = int'($urandom % 10);
                if (r == 9) a = $urandom % b;
                else if (r == 8) a = b + (DEPTH + $urandom % 64) * 4096 + $urandom % 4096;
                else a = b + idx * 4096 + $urandom % 4096;
                if (sel == 3)      do_req(a, 1, 0, 0, 0, 0, 0, "R9");
                else if (sel == 4) do_req(a, 0, 1, int'($urandom % 8), d, 0, 0, "R10");
                else if (sel == 5) do_req(a, 0, 0, 0, 0, 1, d, "R12");
                else               rq(a, "R5");
            end
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule